// File: doc/BRIEF.md
# Block-Mapped Page Address Translator

This block turns a logical page address into a physical block and page for a page-programmed, block-erased storage array. The logical address divides into a virtual block index (upper bits) and an in-block page offset (lower bits). The table holds one row per virtual block, not one per page. Each row names a home block, and may also name an overflow block that takes in rewrites.

The first time a logical page is written, it goes to its own offset inside the home block. A later write to the same logical page cannot overwrite that page. It is appended at the lowest free page of the overflow block, and the block records the logical address as a tag beside that page. A read walks the whole overflow block and takes the highest-numbered page whose tag matches. If no page matches, it falls back to the home page at the offset. Blocks come from an external allocator through a request/grant handshake. When the overflow block fills, the block asks an external agent to merge the two blocks. That virtual block accepts no requests until the agent reports the merge as done, and the row is then cleared.

The block keeps a written flag and a tag for every physical page. It stores no payload data, only placement.

Top module: `blkmap_xlat`

## Requirements
- R1: After reset, req_ready is high for any address, and resp_valid, alloc_req and merge_req are low.
- R2: The virtual block index is req_lpa[LW-1:PW] and the page offset is req_lpa[PW-1:0], with PW = log2(pages per block).
- R3: A write to a virtual block that has no home block raises alloc_req with alloc_vb equal to that index. The block granted on alloc_blk becomes the home block.
- R4: A write whose home page at the offset is still unwritten is placed in the home block at that offset (resp_pba = home block, resp_page = offset), and no allocation is requested.
- R5: A write whose home page is already written, when no overflow block exists, raises alloc_req. The granted block becomes the overflow block.
- R6: Such a rewrite is placed at the lowest-numbered unwritten page of the overflow block, so pages fill in ascending order.
- R7: A read reports the highest-numbered overflow page whose tag equals the read address, with resp_hit = 1. If there is none, it reports the written home page at the offset. If neither exists, resp_hit is 0.
- R8: Tags belonging to other logical addresses in the overflow block do not affect a read. Such a read returns the home page.
- R9: Writing the last page of the overflow block raises merge_req for one cycle, in the same cycle as that write's response. The pulse carries the virtual block, home block and overflow block on merge_vb, merge_pri and merge_rep.
- R10: While a merge is outstanding, req_ready is low whenever req_lpa addresses that virtual block. Other virtual blocks are still served.
- R11: merge_done with merge_done_vb unlocks that virtual block, removes both of its blocks and marks their pages unwritten. Reads then miss, and the next write allocates a new home block.
- R12: resp_valid is a one-cycle pulse for each accepted request. alloc_req stays high, with alloc_vb stable, until alloc_gnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write placement, 0 = read lookup |
| req_lpa | input | LW | Logical page address |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Location valid (always 1 for writes) |
| resp_pba | output | BW | Physical block of the result |
| resp_page | output | PW | Page within that block |
| alloc_req | output | 1 | Needs a fresh block |
| alloc_vb | output | VW | Virtual block needing it |
| alloc_gnt | input | 1 | Allocator grant |
| alloc_blk | input | BW | Granted physical block |
| merge_req | output | 1 | Overflow block just filled |
| merge_vb | output | VW | Virtual block to merge |
| merge_pri | output | BW | Its home block |
| merge_rep | output | BW | Its overflow block |
| merge_done | input | 1 | Merge finished |
| merge_done_vb | input | VW | Virtual block whose merge finished |

## Verification
The hardest state to reach is a full overflow block holding several interleaved rewrites of different logical pages. That state is needed to show the newest-match rule, the fallback to the home page, the merge pulse and the lock. The stimulus reaches it through one virtual block: it writes two home pages, then rewrites them in alternation so that overflow tags interleave, then reads each address. Further rewrites of one address then fill the last page. With the merge still outstanding, the lock is probed from the ready signal for the same virtual block and for another one. The merge is then completed, and the block is shown to read as empty and to allocate afresh.

// File: rtl/blkmap_xlat.sv
module blkmap_xlat #(
  parameter int PPB = 8,
  parameter int NVB = 8,
  parameter int NPB = 16,
  localparam int PW = $clog2(PPB),
  localparam int VW = $clog2(NVB),
  localparam int BW = $clog2(NPB),
  localparam int LW = VW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [LW-1:0] req_lpa,
  output logic          req_ready,
  output logic          resp_valid,
  output logic          resp_hit,
  output logic [BW-1:0] resp_pba,
  output logic [PW-1:0] resp_page,
  output logic          alloc_req,
  output logic [VW-1:0] alloc_vb,
  input  logic          alloc_gnt,
  input  logic [BW-1:0] alloc_blk,
  output logic          merge_req,
  output logic [VW-1:0] merge_vb,
  output logic [BW-1:0] merge_pri,
  output logic [BW-1:0] merge_rep,
  input  logic          merge_done,
  input  logic [VW-1:0] merge_done_vb
);
  localparam int NPG = NPB * PPB;
  localparam logic [PW-1:0] LAST = PW'(PPB - 1);

  typedef enum logic [2:0] {S_IDLE, S_DISP, S_ALLOC, S_WSCAN, S_RSCAN} st_t;
  st_t state;

  logic [LW-1:0] cur_lpa;
  logic          cur_wr;
  logic [PW-1:0] idx, fnd_idx;
  logic          fnd;
  logic [BW-1:0] pri_blk [NVB];
  logic [BW-1:0] rep_blk [NVB];
  logic [NVB-1:0] pri_v, rep_v, lock;
  logic [NPG-1:0] wr_map;
  logic [LW-1:0]  tag_mem [NPG];

  wire [VW-1:0]    cur_vb  = cur_lpa[LW-1:PW];
  wire [PW-1:0]    cur_off = cur_lpa[PW-1:0];
  wire [VW-1:0]    req_vb  = req_lpa[LW-1:PW];
  wire [BW+PW-1:0] pri_pg  = {pri_blk[cur_vb], cur_off};
  wire [BW+PW-1:0] rep_pg  = {rep_blk[cur_vb], idx};
  wire             pri_used = pri_v[cur_vb] && wr_map[pri_pg];
  wire             rep_match = wr_map[rep_pg] && (tag_mem[rep_pg] == cur_lpa);

  assign req_ready = (state == S_IDLE) && !lock[req_vb];
  assign alloc_req = (state == S_ALLOC);
  assign alloc_vb  = cur_vb;

  logic            tag_we;
  logic [BW+PW-1:0] tag_wa;
  always_comb begin
    tag_we = 1'b0;
    tag_wa = pri_pg;
    if (state == S_DISP && cur_wr && pri_v[cur_vb] && !wr_map[pri_pg]) begin
      tag_we = 1'b1;
    end else if (state == S_WSCAN && !wr_map[rep_pg]) begin
      tag_we = 1'b1;
      tag_wa = rep_pg;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_mem[tag_wa] <= cur_lpa;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_lpa    <= '0;
      cur_wr     <= 1'b0;
      idx        <= '0;
      fnd_idx    <= '0;
      fnd        <= 1'b0;
      pri_v      <= '0;
      rep_v      <= '0;
      lock       <= '0;
      wr_map     <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_pba   <= '0;
      resp_page  <= '0;
      merge_req  <= 1'b0;
      merge_vb   <= '0;
      merge_pri  <= '0;
      merge_rep  <= '0;
      for (int v = 0; v < NVB; v++) begin
        pri_blk[v] <= '0;
        rep_blk[v] <= '0;
      end
    end else begin
      resp_valid <= 1'b0;
      merge_req  <= 1'b0;

      if (merge_done) begin
        lock[merge_done_vb]  <= 1'b0;
        pri_v[merge_done_vb] <= 1'b0;
        rep_v[merge_done_vb] <= 1'b0;
        for (int p = 0; p < PPB; p++) begin
          if (pri_v[merge_done_vb]) wr_map[{pri_blk[merge_done_vb], PW'(p)}] <= 1'b0;
          if (rep_v[merge_done_vb]) wr_map[{rep_blk[merge_done_vb], PW'(p)}] <= 1'b0;
        end
      end

      case (state)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            cur_lpa <= req_lpa;
            cur_wr  <= req_write;
            state   <= S_DISP;
          end
        end

        S_DISP: begin
          if (cur_wr) begin
            if (!pri_v[cur_vb]) begin
              state <= S_ALLOC;
            end else if (!wr_map[pri_pg]) begin
              wr_map[pri_pg] <= 1'b1;
              resp_valid     <= 1'b1;
              resp_hit       <= 1'b1;
              resp_pba       <= pri_blk[cur_vb];
              resp_page      <= cur_off;
              state          <= S_IDLE;
            end else if (!rep_v[cur_vb]) begin
              state <= S_ALLOC;
            end else begin
              idx   <= '0;
              state <= S_WSCAN;
            end
          end else if (rep_v[cur_vb]) begin
            idx   <= '0;
            fnd   <= 1'b0;
            state <= S_RSCAN;
          end else begin
            resp_valid <= 1'b1;
            resp_hit   <= pri_used;
            resp_pba   <= pri_blk[cur_vb];
            resp_page  <= cur_off;
            state      <= S_IDLE;
          end
        end

        S_ALLOC: begin
          if (alloc_gnt) begin
            if (!pri_v[cur_vb]) begin
              pri_blk[cur_vb] <= alloc_blk;
              pri_v[cur_vb]   <= 1'b1;
            end else begin
              rep_blk[cur_vb] <= alloc_blk;
              rep_v[cur_vb]   <= 1'b1;
            end
            state <= S_DISP;
          end
        end

        S_WSCAN: begin
          if (!wr_map[rep_pg]) begin
            wr_map[rep_pg] <= 1'b1;
            resp_valid     <= 1'b1;
            resp_hit       <= 1'b1;
            resp_pba       <= rep_blk[cur_vb];
            resp_page      <= idx;
            state          <= S_IDLE;
            if (idx == LAST) begin
              merge_req    <= 1'b1;
              merge_vb     <= cur_vb;
              merge_pri    <= pri_blk[cur_vb];
              merge_rep    <= rep_blk[cur_vb];
              lock[cur_vb] <= 1'b1;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end

        S_RSCAN: begin
          if (idx == LAST) begin
            resp_valid <= 1'b1;
            state      <= S_IDLE;
            if (rep_match || fnd) begin
              resp_hit  <= 1'b1;
              resp_pba  <= rep_blk[cur_vb];
              resp_page <= rep_match ? idx : fnd_idx;
            end else begin
              resp_hit  <= pri_used;
              resp_pba  <= pri_blk[cur_vb];
              resp_page <= cur_off;
            end
          end else begin
            if (rep_match) begin
              fnd     <= 1'b1;
              fnd_idx <= idx;
            end
            idx <= idx + 1'b1;
          end
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  // R12
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R12
  alloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !alloc_gnt |=> alloc_req && $stable(alloc_vb));

  // R9
  merge_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_req |-> resp_valid && resp_page == LAST && resp_pba == merge_rep);

  // R10
  merge_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_req && req_lpa[LW-1:PW] == merge_vb |-> !req_ready);

  // R6
  scan_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WSCAN |-> rep_v[cur_vb] && !lock[cur_vb]);

  // R3
  alloc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> !resp_valid);
endmodule

// File: tb/sim_blkmap_xlat.sv
module sim_blkmap_xlat;
  localparam int PW = 3, VW = 3, BW = 4, LW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [LW-1:0] req_lpa = '0;
  logic req_ready, resp_valid, resp_hit;
  logic [BW-1:0] resp_pba;
  logic [PW-1:0] resp_page;
  logic alloc_req;
  logic [VW-1:0] alloc_vb;
  logic alloc_gnt = 1'b0;
  logic [BW-1:0] alloc_blk = '0;
  logic merge_req;
  logic [VW-1:0] merge_vb;
  logic [BW-1:0] merge_pri, merge_rep;
  logic merge_done = 1'b0;
  logic [VW-1:0] merge_done_vb = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit g_hit, g_merge, g_alloc;
  int g_pba, g_page, g_avb, g_mvb, g_mpri, g_mrep;

  blkmap_xlat u0 (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic xact(input bit wr, input logic [LW-1:0] lpa, input logic [BW-1:0] gblk);
    bit done = 0;
    g_alloc = 0; g_merge = 0; g_hit = 0;
    @(negedge clk);
    req_lpa = lpa; req_write = wr; req_valid = 1'b1;
    for (int t = 0; t < 50 && !req_ready; t++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 100 && !done; t++) begin
      @(negedge clk);
      if (alloc_req) begin
        g_alloc = 1; g_avb = alloc_vb;
        @(negedge clk); @(negedge clk);
        chk(alloc_req == 1'b1 && alloc_vb == g_avb, "R12 alloc held", alloc_req, 1);
        alloc_gnt = 1'b1; alloc_blk = gblk;
        @(negedge clk);
        alloc_gnt = 1'b0;
      end
      if (resp_valid) begin
        done = 1;
        g_hit = resp_hit; g_pba = resp_pba; g_page = resp_page;
        g_merge = merge_req; g_mvb = merge_vb; g_mpri = merge_pri; g_mrep = merge_rep;
        @(negedge clk);
        chk(resp_valid == 1'b0, "R12 resp pulse", resp_valid, 0);
      end
    end
    chk(done, "R12 response arrives", done, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(resp_valid == 1'b0 && alloc_req == 1'b0 && merge_req == 1'b0, "R1 idle outputs",
        {resp_valid, alloc_req, merge_req}, 0);
  endtask

  task automatic t_first_writes();
    xact(1, 6'h0A, 4'd5);
    chk(g_alloc && g_avb == 1, "R3 alloc vb", g_avb, 1);
    chk(g_pba == 5 && g_page == 2, "R2 R4 home placement", g_pba*8 + g_page, 42);
    xact(1, 6'h0B, 4'd0);
    chk(!g_alloc, "R4 no alloc", g_alloc, 0);
    chk(g_pba == 5 && g_page == 3, "R4 offset 3", g_pba*8 + g_page, 43);
  endtask

  task automatic t_rewrites();
    xact(1, 6'h0A, 4'd9);
    chk(g_alloc && g_avb == 1, "R5 overflow alloc", g_alloc, 1);
    chk(g_pba == 9 && g_page == 0, "R5 R6 page0", g_pba*8 + g_page, 72);
    xact(1, 6'h0B, 4'd0);
    chk(!g_alloc && g_pba == 9 && g_page == 1, "R6 page1", g_pba*8 + g_page, 73);
    xact(1, 6'h0A, 4'd0);
    chk(g_pba == 9 && g_page == 2, "R6 page2", g_pba*8 + g_page, 74);
  endtask

  task automatic t_reads();
    xact(0, 6'h0A, 4'd0);
    chk(g_hit && g_pba == 9 && g_page == 2, "R7 newest match", g_pba*8 + g_page, 74);
    xact(0, 6'h0B, 4'd0);
    chk(g_hit && g_pba == 9 && g_page == 1, "R7 match 0B", g_pba*8 + g_page, 73);
    xact(0, 6'h0C, 4'd0);
    chk(!g_hit, "R7 unwritten miss", g_hit, 0);
    xact(0, 6'h33, 4'd0);
    chk(!g_hit && !g_alloc, "R7 no home miss", g_hit, 0);
    xact(1, 6'h08, 4'd0);
    xact(0, 6'h08, 4'd0);
    chk(g_hit && g_pba == 5 && g_page == 0, "R8 home fallback", g_pba*8 + g_page, 40);
  endtask

  task automatic t_fill_merge();
    for (int k = 3; k < 8; k++) begin
      xact(1, 6'h0A, 4'd0);
      chk(g_pba == 9 && g_page == k, "R6 fill", g_page, k);
      if (k < 7) chk(!g_merge, "R9 no early merge", g_merge, 0);
    end
    chk(g_merge && g_mvb == 1 && g_mpri == 5 && g_mrep == 9, "R9 merge fields",
        g_mvb*256 + g_mpri*16 + g_mrep, 256 + 80 + 9);
    @(negedge clk);
    chk(merge_req == 1'b0, "R9 merge pulse", merge_req, 0);
  endtask

  task automatic t_lock();
    @(negedge clk);
    req_lpa = 6'h0D;
    #1 chk(req_ready == 1'b0, "R10 locked vb", req_ready, 0);
    req_lpa = 6'h12;
    #1 chk(req_ready == 1'b1, "R10 other vb", req_ready, 1);
    xact(1, 6'h12, 4'd3);
    chk(g_pba == 3 && g_page == 2, "R10 other vb served", g_pba*8 + g_page, 26);
  endtask

  task automatic t_merge_done();
    @(negedge clk);
    merge_done = 1'b1; merge_done_vb = 3'd1;
    @(negedge clk);
    merge_done = 1'b0;
    req_lpa = 6'h0A;
    #1 chk(req_ready == 1'b1, "R11 unlocked", req_ready, 1);
    xact(0, 6'h0A, 4'd0);
    chk(!g_hit, "R11 read after merge", g_hit, 0);
    xact(1, 6'h0A, 4'd5);
    chk(g_alloc && g_avb == 1, "R11 fresh alloc", g_alloc, 1);
    chk(g_pba == 5 && g_page == 2, "R11 new home", g_pba*8 + g_page, 42);
    xact(0, 6'h12, 4'd0);
    chk(g_hit && g_pba == 3 && g_page == 2, "R11 other vb intact", g_pba*8 + g_page, 26);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_writes();
    t_rewrites();
    t_reads();
    t_fill_merge();
    t_lock();
    t_merge_done();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule